// File: doc/BRIEF.md
# SONET/SDH Frame Alignment Detector

This block takes a serial line, one bit per clock, and finds the byte boundary of the SONET/SDH framing pattern. The pattern is a run of A1 bytes (0xF6) followed by A2 bytes (0x28). The search runs only while the hunt input is high. The search window ends at the third A2 byte, and it is compared at every bit offset on every clock.

When the window matches, the block emits a one-clock frame pulse. It then restarts its byte counter, so that every later byte handed out is cut on the boundary it has just found. While the hunt input is low, the boundary stays where it is, even if framing bytes appear at another offset.

A rate input selects how many A1 bytes must come before the A2 bytes: three for STS-3, twelve for STS-12. The parallel side is a byte bus with a one-clock valid strobe, which fires once every eight bit clocks. Downstream logic uses the strobe as the parallel clock enable.

Top module: `fa_frame_align`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `frame_pls` and `byte_vld` are 0 and `byte_out` is 0x00.
- R2: `frame_pls` is high for exactly one clock. In that clock, `byte_vld` is 1 and `byte_out` carries the third A2 byte, 0x28.
- R3: Bits arrive MSB first. `frame_pls` rises on the clock edge that takes in the bit following the last bit of the third A2 byte.
- R4: With `rate_hi`=0 the pattern is 3 bytes of 0xF6 and then 3 bytes of 0x28. With `rate_hi`=1 it is 12 bytes of 0xF6 and then 3 bytes of 0x28. Longer A1 runs are accepted in either mode. A shorter A1 run gives no pulse.
- R5: A match produces a pulse and moves the boundary only if `hunt_en` is 1 at the edge that would raise the pulse. With `hunt_en`=0, no pulse appears and `byte_vld` keeps its previous 8-clock phase.
- R6: After a pulse, `byte_vld` rises every 8 clocks. Each `byte_out` holds the 8 bits received since the previous strobe, with the earliest bit in bit 7.
- R7: Detection and realignment work at any bit offset of the pattern relative to the previous boundary. This includes an offset equal to the old boundary, where the pulse coincides with a regular byte strobe.
- R8: `byte_out` changes only in clocks where `byte_vld` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock; one line bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial line data, MSB of each byte first |
| hunt_en | input | 1 | Out-of-frame level; high enables frame search |
| rate_hi | input | 1 | 0 = STS-3 (3 A1 bytes), 1 = STS-12 (12 A1 bytes) |
| byte_out | output | 8 | Byte-aligned parallel data |
| byte_vld | output | 1 | One-clock strobe marking a new byte on `byte_out` |
| frame_pls | output | 1 | One-clock pulse on detection of the third A2 byte |

## Verification
A frame match and a regular byte strobe can fall on the same clock edge. This happens when the new boundary lines up with the old one. If the pattern is shifted by one bit, the match instead comes one clock after a regular strobe. The stimulus table provokes both cases by choosing the idle-bit offset ahead of each pattern: a multiple of eight keeps the old phase, and any other count moves it. The result is judged at the ports. The pulse must land on the expected bit, it must come with exactly one strobe, and every later strobe must carry the bits the bench itself recorded, taken on the new phase.

// File: rtl/fa_pkg.sv
package fa_pkg;
  localparam int unsigned BYTE_BITS = 8;
  localparam logic [BYTE_BITS-1:0] FRAME_A1 = 8'hF6;
  localparam logic [BYTE_BITS-1:0] FRAME_A2 = 8'h28;
  localparam int unsigned A1_RUN_STS3  = 3;
  localparam int unsigned A1_RUN_STS12 = 12;
  localparam int unsigned A2_TO_PULSE  = 3;
endpackage

// File: rtl/fa_hist.sv
module fa_hist #(
  parameter int unsigned DEPTH = 120
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  output logic [DEPTH-1:0] hist
);
  // hist[0] is the newest bit; older bits move toward the top.
  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else     hist <= {hist[DEPTH-2:0], din};
  end
endmodule

// File: rtl/fa_match.sv
module fa_match #(
  parameter int unsigned         BYTE_W = 8,
  parameter int unsigned         A1_LO  = 3,
  parameter int unsigned         A1_HI  = 12,
  parameter int unsigned         A2_N   = 3,
  parameter logic [BYTE_W-1:0]   A1_VAL = 8'hF6,
  parameter logic [BYTE_W-1:0]   A2_VAL = 8'h28,
  localparam int unsigned        DEPTH  = (A1_HI + A2_N) * BYTE_W
) (
  input  logic [DEPTH-1:0] hist,
  input  logic             rate_hi,
  output logic             match
);
  logic [A2_N-1:0]  a2_ok;
  logic [A1_HI-1:0] a1_ok;
  logic [A1_HI-1:0] a1_need;

  // Byte slot 0 is the newest full byte (third A2 byte).
  for (genvar g = 0; g < A2_N; g++) begin : g_a2
    assign a2_ok[g] = (hist[g*BYTE_W +: BYTE_W] == A2_VAL);
  end

  // A1 slot 0 is the last A1 byte, just ahead of the first A2.
  for (genvar k = 0; k < A1_HI; k++) begin : g_a1
    assign a1_ok[k]   = (hist[(A2_N+k)*BYTE_W +: BYTE_W] == A1_VAL);
    assign a1_need[k] = (k < A1_LO) ? 1'b1 : rate_hi;
  end

  assign match = (&a2_ok) & (&(a1_ok | ~a1_need));
endmodule

// File: rtl/fa_deser.sv
module fa_deser #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = $clog2(BYTE_W),
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] newest,
  input  logic              hit,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_vld,
  output logic              frame_pls
);
  logic [CNT_W-1:0] phase;
  logic             full;

  assign full = (phase == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      byte_out  <= '0;
      byte_vld  <= 1'b0;
      frame_pls <= 1'b0;
    end else begin
      frame_pls <= hit;
      if (hit) begin
        // newest holds a complete byte on the new boundary
        phase    <= '0;
        byte_vld <= 1'b1;
        byte_out <= newest;
      end else begin
        phase    <= full ? '0 : phase + 1'b1;
        byte_vld <= full;
        if (full) byte_out <= newest;
      end
    end
  end
endmodule

// File: rtl/fa_frame_align.sv
module fa_frame_align #(
  parameter int unsigned       BYTE_W = fa_pkg::BYTE_BITS,
  parameter int unsigned       A1_LO  = fa_pkg::A1_RUN_STS3,
  parameter int unsigned       A1_HI  = fa_pkg::A1_RUN_STS12,
  parameter int unsigned       A2_N   = fa_pkg::A2_TO_PULSE,
  parameter logic [BYTE_W-1:0] A1_VAL = fa_pkg::FRAME_A1,
  parameter logic [BYTE_W-1:0] A2_VAL = fa_pkg::FRAME_A2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_in,
  input  logic              hunt_en,
  input  logic              rate_hi,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_vld,
  output logic              frame_pls
);
  localparam int unsigned DEPTH = (A1_HI + A2_N) * BYTE_W;

  logic [DEPTH-1:0] hist;
  logic             match;
  logic             hit;

  fa_hist #(.DEPTH(DEPTH)) u_hist (
    .clk (clk),
    .rst (rst),
    .din (ser_in),
    .hist(hist)
  );

  fa_match #(
    .BYTE_W(BYTE_W), .A1_LO(A1_LO), .A1_HI(A1_HI), .A2_N(A2_N),
    .A1_VAL(A1_VAL), .A2_VAL(A2_VAL)
  ) u_match (
    .hist   (hist),
    .rate_hi(rate_hi),
    .match  (match)
  );

  assign hit = match & hunt_en;

  fa_deser #(.BYTE_W(BYTE_W)) u_deser (
    .clk      (clk),
    .rst      (rst),
    .newest   (hist[BYTE_W-1:0]),
    .hit      (hit),
    .byte_out (byte_out),
    .byte_vld (byte_vld),
    .frame_pls(frame_pls)
  );
endmodule

// File: rtl/fa_frame_align_chk.sv
module fa_frame_align_chk #(
  parameter int unsigned       BYTE_W = 8,
  parameter logic [BYTE_W-1:0] A2_VAL = 8'h28
) (
  input logic              clk,
  input logic              rst,
  input logic              hunt_en,
  input logic [BYTE_W-1:0] byte_out,
  input logic              byte_vld,
  input logic              frame_pls
);
  logic [4:0] gap;

  always_ff @(posedge clk) begin
    if (rst)           gap <= '0;
    else if (byte_vld) gap <= 5'd1;
    else if (gap != 5'd31) gap <= gap + 5'd1;
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (!frame_pls && !byte_vld && byte_out == '0));

  a_r2_pulse_single: assert property (@(posedge clk) disable iff (rst)
    frame_pls |=> !frame_pls);

  a_r2_pulse_carries_a2: assert property (@(posedge clk) disable iff (rst)
    frame_pls |-> (byte_vld && byte_out == A2_VAL));

  a_r5_pulse_needs_hunt: assert property (@(posedge clk) disable iff (rst)
    frame_pls |-> $past(hunt_en));

  a_r6_regular_spacing: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && !frame_pls) |-> (gap == 5'(BYTE_W)));

  a_r6_no_long_gap: assert property (@(posedge clk) disable iff (rst)
    gap <= 5'(BYTE_W));

  a_r8_data_holds: assert property (@(posedge clk) disable iff (rst)
    !byte_vld |-> $stable(byte_out));
endmodule

bind fa_frame_align fa_frame_align_chk #(.BYTE_W(BYTE_W), .A2_VAL(A2_VAL)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .hunt_en  (hunt_en),
  .byte_out (byte_out),
  .byte_vld (byte_vld),
  .frame_pls(frame_pls)
);

// File: tb/fa_frame_align_tb.sv
module fa_frame_align_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       ser_in;
  logic       hunt_en;
  logic       rate_hi;
  logic [7:0] byte_out;
  logic       byte_vld;
  logic       frame_pls;

  always #5 clk = ~clk;

  fa_frame_align u_dut (
    .clk(clk), .rst(rst), .ser_in(ser_in), .hunt_en(hunt_en), .rate_hi(rate_hi),
    .byte_out(byte_out), .byte_vld(byte_vld), .frame_pls(frame_pls)
  );

  // {offset[4], rate_hi, a1_count[4], hunt_en, expect_pulse, pad[5], follow[8]}
  localparam logic [23:0] VEC [11] = '{
    {4'd0,  1'b0, 4'd3,  1'b1, 1'b1, 5'd0, 8'h5A},
    {4'd3,  1'b0, 4'd3,  1'b1, 1'b1, 5'd0, 8'hC3},
    {4'd5,  1'b1, 4'd12, 1'b1, 1'b1, 5'd0, 8'h3C},
    {4'd7,  1'b1, 4'd3,  1'b1, 1'b0, 5'd0, 8'h81},
    {4'd1,  1'b0, 4'd12, 1'b1, 1'b1, 5'd0, 8'h77},
    {4'd6,  1'b0, 4'd3,  1'b0, 1'b0, 5'd0, 8'h99},
    {4'd2,  1'b1, 4'd12, 1'b0, 1'b0, 5'd0, 8'hE7},
    {4'd8,  1'b1, 4'd12, 1'b1, 1'b1, 5'd0, 8'h0F},
    {4'd9,  1'b0, 4'd2,  1'b1, 1'b0, 5'd0, 8'h11},
    {4'd13, 1'b0, 4'd3,  1'b1, 1'b1, 5'd0, 8'hA5},
    {4'd0,  1'b1, 4'd12, 1'b1, 1'b1, 5'd0, 8'h66}
  };

  int         checks = 0;
  int         errors = 0;
  int         bitno  = 0;
  int         pulses = 0;
  int         pulse_bit = 0;
  logic [7:0] pulse_word = '0;
  bit         ref_ok = 1'b0;
  int         ref_mod = 0;
  logic [7:0] prev_word = '0;
  logic       hist [4096];
  logic [8:0] wlog [4096];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    logic [7:0] e;
    ser_in = b;
    @(posedge clk);
    @(negedge clk);
    bitno++;
    hist[bitno % 4096] = b;
    wlog[bitno % 4096] = {byte_vld, byte_out};
    if (frame_pls) begin
      pulses++;
      pulse_bit  = bitno;
      pulse_word = byte_out;
      ref_ok     = 1'b1;
      ref_mod    = bitno % 8;
      chk(byte_vld === 1'b1, "R2 strobe with pulse", int'(byte_vld), 1);
    end
    if (!byte_vld)
      chk(byte_out === prev_word, "R8 data held between strobes", int'(byte_out), int'(prev_word));
    if (byte_vld && ref_ok) begin
      for (int i = 0; i < 8; i++) e[7-i] = hist[(bitno - 8 + i) % 4096];
      chk(bitno % 8 == ref_mod, "R5 R6 strobe phase", bitno % 8, ref_mod);
      chk(byte_out === e, "R6 byte content", int'(byte_out), int'(e));
    end
    prev_word = byte_out;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic run_vec(input logic [23:0] v);
    int p, p0, got;
    rate_hi = v[19];
    hunt_en = v[14];
    p0 = pulses;
    repeat (int'(v[23:20])) send_bit(1'b0);
    repeat (int'(v[18:15])) send_byte(8'hF6);
    repeat (3) send_byte(8'h28);
    p = bitno;
    send_byte(v[7:0]);
    repeat (16) send_bit(1'b0);
    got = pulses - p0;
    // R3 timing, R4 A1 run length, R5 hunt gating
    chk(got == int'(v[13]), "R3 R4 R5 pulse count", got, int'(v[13]));
    if (v[13]) begin
      chk(pulse_bit == p + 1, "R3 pulse position", pulse_bit, p + 1);
      chk(pulse_word == 8'h28, "R2 pulse word", int'(pulse_word), 'h28);
      chk(wlog[(p + 9) % 4096] == {1'b1, v[7:0]}, "R7 R6 first aligned byte",
          int'(wlog[(p + 9) % 4096]), int'({1'b1, v[7:0]}));
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    ser_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!frame_pls && !byte_vld, "R1 strobes low in reset", int'({frame_pls, byte_vld}), 0);
    chk(byte_out === 8'h00, "R1 data zero in reset", int'(byte_out), 0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(!frame_pls && !byte_vld && byte_out === 8'h00, "R1 quiet after reset",
        int'({frame_pls, byte_vld, byte_out}), 0);
    ref_ok = 1'b0;
    prev_word = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    hunt_en = 1'b0;
    rate_hi = 1'b0;
    do_reset();
    // table walk: offsets, rates, A1 run lengths, hunt gating (R3 R4 R5 R7)
    for (int v = 0; v < 11; v++) run_vec(VEC[v]);
    // reset mid-stream, then hunt again at an odd offset
    do_reset();
    run_vec({4'd11, 1'b0, 4'd3, 1'b1, 1'b1, 5'd0, 8'hD2});
    // pattern lands exactly on the old boundary: pulse and regular strobe coincide (R7)
    run_vec({4'd8, 1'b0, 4'd3, 1'b1, 1'b1, 5'd0, 8'h4B});
    // hunt low with a shifted pattern: boundary must stay put (R5)
    run_vec({4'd5, 1'b0, 4'd3, 1'b0, 1'b0, 5'd0, 8'hB4});
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule